// File: doc/BRIEF.md
# Trip Flag and Interrupt Latch

This block keeps the protection trip state for one PWM channel. Two latched trip flags are held: a one-shot latch, which stays set until software removes it, and a cycle-by-cycle latch. The cycle-by-cycle latch also drives a trip status that releases itself at a PWM period boundary once its hardware trip input has gone inactive. A hardware event or a software force sets either latch.

A global interrupt flag decides when the channel raises a one-clock interrupt pulse. The flag is set and a pulse issued whenever a trip latch is set while the global flag is clear. No further pulse is issued while the global flag stays set. Clearing the global flag while a latch is still set produces a new pulse. Clearing every flag stops the pulses.

Software reaches the block through a simple write/read bus with three registers: a read-only flag register, a write-one-to-clear register and a force register. The trip status outputs go to the PWM output stage.

Top module: `trip_latch_ctl`

## Requirements
- R1: After a synchronous active-low reset, all three flags, both trip status outputs and the interrupt pulse are 0, and the flag register reads 0.
- R2: Register addresses are flag = 0, clear = 1, force = 2. The flag register returns the one-shot latch in bit 2, the cycle-by-cycle latch in bit 1 and the global interrupt flag in bit 0. Its bits 15..3 read 0, and address 3 reads 0.
- R3: The clear and force registers always read back as all zeros.
- R4: A high hardware one-shot trip input sets the one-shot latch at the next clock edge. The latch and its status output then stay set until software clears the latch.
- R5: A high hardware cycle-by-cycle trip input sets the cycle-by-cycle latch and its status output at the next edge. The status output falls at an edge where the period strobe is high and the trip input is low. The latch flag itself stays set.
- R6: Writing 1 to a bit of the clear register (bit 2 one-shot, bit 1 cycle-by-cycle, bit 0 global) clears that flag at that edge. Writing 0 to a bit leaves its flag unchanged.
- R7: Writing 1 to force-register bit 2 or bit 1 sets the one-shot or cycle-by-cycle latch, and a cycle-by-cycle force also sets its status output. Writing 0, or writing force bit 0, changes nothing.
- R8: When a set event and a clear hit the same flag in one cycle, the flag ends up set. A period strobe in the same cycle as a cycle-by-cycle set leaves the status output set.
- R9: One clock after a trip latch becomes set while the global flag is clear, the global flag sets and the interrupt output is high for exactly one clock.
- R10: While the global flag is set, a newly set latch produces no interrupt pulse.
- R11: Clearing the global flag while a trip latch is still set produces an interrupt pulse one clock after the clear write.
- R12: After all three flags have been cleared, no interrupt pulse occurs until a new trip is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trip_ost_i | input | 1 | Hardware one-shot trip event |
| trip_cbc_i | input | 1 | Hardware cycle-by-cycle trip level |
| period_stb_i | input | 1 | PWM period-boundary strobe |
| wr_en_i | input | 1 | Register write enable |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for addr_i |
| irq_o | output | 1 | One-clock trip interrupt pulse |
| ost_trip_o | output | 1 | One-shot trip status |
| cbc_trip_o | output | 1 | Cycle-by-cycle trip status |

## Verification
Three same-cycle collisions matter here. A hardware trip can land in the same cycle as a clear write to its latch. A pending interrupt request can meet a write that clears the global flag. A cycle-by-cycle trip can coincide with the period strobe. The stimulus table drives each pair in a single vector. The flags are then read back in the next vector, and the test passes when the set side has won: the latch still reads 1, the pulse fires and the global flag stays set, and the status output stays high.

// File: rtl/trip_pkg.sv
// Shared constants and types for the trip flag and interrupt latch.
// Assumes a small register window addressed by a short word index.
package trip_pkg;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 2;
    // bit positions shared by the flag, clear and force registers
    localparam int POS_OST = 2;
    localparam int POS_CBC = 1;
    localparam int POS_INT = 0;
    localparam int N_LATCH = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_FLAG  = 2'd0,
        SEL_CLEAR = 2'd1,
        SEL_FORCE = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ost;
        logic cbc;
        logic gint;
    } trip_bits_t;
endpackage

// File: rtl/trip_regif.sv
// Register decode: turns bus writes into one-cycle clear and force strobes
// and returns read data. Assumes a single-cycle write with no wait states;
// clear and force registers hold no state and read as zero.
module trip_regif
    import trip_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  trip_bits_t    flags_i,
    output trip_bits_t    clr_o,
    output trip_bits_t    frc_o,
    output logic [DW-1:0] rdata_o
);
    localparam int NFLAG = $bits(trip_bits_t);

    logic wr_clear;
    logic wr_force;

    // decode which register a write targets
    always_comb begin
        wr_clear = wr_en_i && (addr_i == AW'(SEL_CLEAR));
        wr_force = wr_en_i && (addr_i == AW'(SEL_FORCE));
    end

    // clear strobes for all three flags, force strobes for the two latches only
    always_comb begin
        clr_o      = '0;
        frc_o      = '0;
        clr_o.ost  = wr_clear & wdata_i[POS_OST];
        clr_o.cbc  = wr_clear & wdata_i[POS_CBC];
        clr_o.gint = wr_clear & wdata_i[POS_INT];
        frc_o.ost  = wr_force & wdata_i[POS_OST];
        frc_o.cbc  = wr_force & wdata_i[POS_CBC];
    end

    // read mux: only the flag register returns live data
    always_comb begin
        rdata_o = '0;
        if (addr_i == AW'(SEL_FLAG)) begin
            rdata_o[NFLAG-1:0] = flags_i;
        end
    end
endmodule

// File: rtl/trip_flag_cell.sv
// One sticky flag bit with set priority over clear.
// Assumes set and clear are single-clock strobes or levels from this clock domain.
module trip_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // hold the flag; set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    // R6
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
    // R6
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/trip_cbc_hold.sv
// Cycle-by-cycle trip status: raised by a trip, released at a period
// boundary once the hardware trip level is low. Assumes the period strobe
// is one clock wide and already aligned to this clock.
module trip_cbc_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic period_i,
    input  logic trip_lvl_i,
    output logic q_o
);
    // release only on a boundary with the input quiet; a new set wins
    always_ff @(posedge clk) begin
        if (!rst_n)                        q_o <= 1'b0;
        else if (set_i)                    q_o <= 1'b1;
        else if (period_i && !trip_lvl_i)  q_o <= 1'b0;
    end

    // R5
    cbc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i && !trip_lvl_i && !set_i) |=> !q_o);
    // R5
    cbc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/trip_irq_gen.sv
// Global interrupt flag and pulse generator. A request exists whenever any
// trip latch is set while the global flag is clear; servicing it sets the
// flag and emits a one-clock pulse. Assumes latch flags come from registers.
module trip_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic latch_any_i,
    input  logic clr_i,
    output logic gint_o,
    output logic irq_o
);
    logic req;

    // request when a latch is set and no interrupt is outstanding
    always_comb req = latch_any_i && !gint_o;

    // global flag: request sets it (wins over clear), clear write drops it
    always_ff @(posedge clk) begin
        if (!rst_n)     gint_o <= 1'b0;
        else if (req)   gint_o <= 1'b1;
        else if (clr_i) gint_o <= 1'b0;
    end

    // registered pulse, one clock per serviced request
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= req;
    end

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    // R10
    no_pulse_when_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gint_o |=> !irq_o);
    // R11
    repulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gint_o && latch_any_i) |=> (irq_o && gint_o));
    // R12
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_any_i |=> !irq_o);
endmodule

// File: rtl/trip_latch_ctl.sv
// Trip flag and interrupt latch for one PWM channel: one-shot and
// cycle-by-cycle latches, cycle-by-cycle status, global interrupt flag and
// a register window. Assumes trip inputs are already synchronised.
module trip_latch_ctl
    import trip_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trip_ost_i,
    input  logic          trip_cbc_i,
    input  logic          period_stb_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          irq_o,
    output logic          ost_trip_o,
    output logic          cbc_trip_o
);
    trip_bits_t         flags;
    trip_bits_t         clr;
    trip_bits_t         frc;
    logic [N_LATCH-1:0] lat_set;
    logic [N_LATCH-1:0] lat_clr;
    logic [N_LATCH-1:0] lat_q;
    logic               gint;

    trip_regif #(.DW(DW), .AW(AW)) u_regif (
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .flags_i (flags),
        .clr_o   (clr),
        .frc_o   (frc),
        .rdata_o (rdata_o)
    );

    // index 1 = one-shot, index 0 = cycle-by-cycle
    always_comb begin
        lat_set = {trip_ost_i | frc.ost, trip_cbc_i | frc.cbc};
        lat_clr = {clr.ost, clr.cbc};
    end

    for (genvar g = 0; g < N_LATCH; g++) begin : g_latch
        trip_flag_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (lat_set[g]),
            .clr_i (lat_clr[g]),
            .q_o   (lat_q[g])
        );
    end

    trip_cbc_hold u_cbc_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (lat_set[0]),
        .period_i   (period_stb_i),
        .trip_lvl_i (trip_cbc_i),
        .q_o        (cbc_trip_o)
    );

    trip_irq_gen u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .latch_any_i (|lat_q),
        .clr_i       (clr.gint),
        .gint_o      (gint),
        .irq_o       (irq_o)
    );

    // gather flag register view and status outputs
    always_comb begin
        flags.ost  = lat_q[1];
        flags.cbc  = lat_q[0];
        flags.gint = gint;
        ost_trip_o = lat_q[1];
    end

    // R4
    ost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ost_trip_o && !clr.ost) |=> ost_trip_o);
    // R3
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i != AW'(SEL_FLAG)) |-> (rdata_o == '0));
endmodule

// File: tb/trip_latch_ctl_bench.sv
`timescale 1ns/1ps
module trip_latch_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trip_ost_i = 1'b0;
    logic        trip_cbc_i = 1'b0;
    logic        period_stb_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  addr_i = 2'd0;
    logic [15:0] wdata_i = 16'd0;
    logic [15:0] rdata_o;
    logic        irq_o;
    logic        ost_trip_o;
    logic        cbc_trip_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trip_latch_ctl u_trip_latch_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .trip_ost_i   (trip_ost_i),
        .trip_cbc_i   (trip_cbc_i),
        .period_stb_i (period_stb_i),
        .wr_en_i      (wr_en_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .rdata_o      (rdata_o),
        .irq_o        (irq_o),
        .ost_trip_o   (ost_trip_o),
        .cbc_trip_o   (cbc_trip_o)
    );

    // vector: ost cbc per wr addr[1:0] wdata[2:0] | irq ost_o cbc_o rd[2:0]
    // expected values are the outputs after the clock edge that applies the vector
    localparam int NV = 32;
    localparam logic [14:0] VEC [NV] = '{
        15'b0_0_0_0_00_000_0_0_0_000, // 0  idle, R2
        15'b1_0_0_0_00_000_0_1_0_100, // 1  hw one-shot, R4
        15'b0_0_0_0_00_000_1_1_0_101, // 2  pulse, R9
        15'b0_0_0_0_00_000_0_1_0_101, // 3  single pulse, R9
        15'b0_1_0_0_00_000_0_1_1_111, // 4  cbc while global set, R10
        15'b0_0_0_0_00_000_0_1_1_111, // 5  status held, R5
        15'b0_0_1_0_00_000_0_1_0_111, // 6  period release, R5
        15'b0_0_0_1_01_000_0_1_0_000, // 7  clear with 0s, R6 R3
        15'b0_0_0_0_00_000_0_1_0_111, // 8  unchanged, R6
        15'b0_0_0_1_01_001_0_1_0_000, // 9  clear global, R11
        15'b0_0_0_0_00_000_1_1_0_111, // 10 re-pulse, R11
        15'b0_0_0_1_01_111_0_0_0_000, // 11 clear all, R12
        15'b0_0_0_0_00_000_0_0_0_000, // 12 quiet, R12
        15'b0_0_0_0_00_000_0_0_0_000, // 13 quiet, R12
        15'b0_0_0_1_10_010_0_0_1_000, // 14 force cbc, R7 R3
        15'b0_0_0_0_00_000_1_0_1_011, // 15 pulse, R9
        15'b0_0_0_1_10_001_0_0_1_000, // 16 force bit0 ignored, R7
        15'b0_0_0_0_00_000_0_0_1_011, // 17 unchanged, R7
        15'b0_1_1_0_00_000_0_0_1_011, // 18 period with input high, R5
        15'b0_0_1_0_00_000_0_0_0_011, // 19 period input low, R5
        15'b0_0_0_1_10_100_0_1_0_000, // 20 force one-shot, R7
        15'b0_0_0_0_00_000_0_1_0_111, // 21 no pulse, R10
        15'b1_0_0_1_01_100_0_1_0_000, // 22 hw set + clear, R8
        15'b0_0_0_0_00_000_0_1_0_111, // 23 still set, R8
        15'b0_0_0_1_01_110_0_0_0_000, // 24 clear latches, R6
        15'b0_0_0_0_00_000_0_0_0_001, // 25 global remains, R6
        15'b0_0_0_1_01_001_0_0_0_000, // 26 clear global, R12
        15'b0_0_0_0_00_000_0_0_0_000, // 27 no pulse, R12
        15'b0_1_0_0_00_000_0_0_1_010, // 28 cbc trip, R5
        15'b0_0_0_1_01_001_1_0_1_000, // 29 request + clear global, R8
        15'b0_0_0_0_00_000_0_0_1_011, // 30 global kept, R8
        15'b0_1_1_0_00_000_0_0_1_011  // 31 cbc set + period, R8
    };
    localparam int VREQ [NV] = '{2,4,9,9,10,5,5,6,6,11,11,12,12,12,7,9,
                                 7,7,5,5,7,10,8,8,6,6,12,12,5,8,8,8};

    task automatic check(input int req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic o, input logic c, input logic p, input logic w,
                         input logic [1:0] a, input logic [15:0] d);
        trip_ost_i = o; trip_cbc_i = c; period_stb_i = p;
        wr_en_i = w; addr_i = a; wdata_i = d;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #50000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(1, "irq after reset", int'(irq_o), 0);
        check(1, "flags after reset", int'(rdata_o), 0);
        check(1, "status after reset", int'({ost_trip_o, cbc_trip_o}), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [14:0] v;
            v = VEC[i];
            drive(v[14], v[13], v[12], v[11], v[10:9], {13'd0, v[8:6]});
            @(negedge clk);
            check(VREQ[i], $sformatf("vec %0d irq", i), int'(irq_o), int'(v[5]));
            check(VREQ[i], $sformatf("vec %0d ost_trip", i), int'(ost_trip_o), int'(v[4]));
            check(VREQ[i], $sformatf("vec %0d cbc_trip", i), int'(cbc_trip_o), int'(v[3]));
            check(VREQ[i], $sformatf("vec %0d rdata", i), int'(rdata_o), int'(v[2:0]));
        end

        // R2: upper bits of the flag register and unmapped address read 0
        drive(1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 16'hFFFF); // force all bits
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 16'd0);
        @(negedge clk);
        check(2, "flag reg all set", int'(rdata_o), 7);
        addr_i = 2'd3;
        #1;
        check(2, "unmapped address", int'(rdata_o), 0);
        // R3: clear register reads zero even with data on the bus
        addr_i = 2'd1;
        wdata_i = 16'hFFFF;
        #1;
        check(3, "clear reg readback", int'(rdata_o), 0);
        addr_i = 2'd0;
        wdata_i = 16'd0;

        // R1: synchronous reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check(1, "flags in reset", int'(rdata_o), 0);
        check(1, "status in reset", int'({ost_trip_o, cbc_trip_o, irq_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, "quiet after reset", int'(irq_o), 0);

        finish_run();
    end
endmodule